// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block raises and clears the interrupt lines that two agents use to signal each other through a shared 2K x 8 dual-port memory. Each side, port A and port B, has its own chip select, write strobe, output enable, 11-bit address and busy input. All of these are active low and are sampled on one common clock. The block keeps one interrupt flag per port and drives it out as an active-low request.

The two highest addresses act as mailboxes. Port A sends to port B by writing address 0x7FF, and port B sends to port A by writing address 0x7FE. The receiving port acknowledges by reading its own mailbox address, which clears its flag. These accesses are ordinary memory cycles: the interrupt change is only a side effect. When the busy input of the accessing port is low, that access leaves both flags unchanged.

Memory storage, address arbitration and data pins are handled elsewhere. This block only decodes the strobes and holds the two flags.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset, both `a_irq_n` and `b_irq_n` are high.
- R2: A cycle with `a_cs_n`=0, `a_we_n`=0, `a_addr`=0x7FF and `a_busy_n`=1 sets port B's flag, so `b_irq_n` is low after that clock edge.
- R3: A cycle with `b_cs_n`=0, `b_oe_n`=0, `b_addr`=0x7FF and `b_busy_n`=1 clears port B's flag, whatever `b_we_n` is. `b_irq_n` returns high.
- R4: A cycle with `b_cs_n`=0, `b_we_n`=0, `b_addr`=0x7FE and `b_busy_n`=1 sets port A's flag, driving `a_irq_n` low.
- R5: A cycle with `a_cs_n`=0, `a_oe_n`=0, `a_addr`=0x7FE and `a_busy_n`=1 clears port A's flag, driving `a_irq_n` high.
- R6: An access made while the accessing port's busy input is low changes neither flag.
- R7: When a set and a clear of the same flag occur in the same cycle, the flag ends up set.
- R8: Accesses with chip select high, or to any address other than the two mailboxes, leave both flags unchanged. A port writing its own receive mailbox or reading its send mailbox also has no effect.
- R9: Each flag is a register. Its output changes only at the clock edge that samples the access, with exactly one cycle of latency, and the block's state matches a reference model on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | 11 | Port A address |
| a_busy_n | input | 1 | Port A busy, low cancels port A's effect |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | 11 | Port B address |
| b_busy_n | input | 1 | Port B busy, low cancels port B's effect |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
The assertions assume that every control and address input holds a known level, is stable around each rising clock edge, and counts as one access per cycle in which it is held. The bench changes all inputs only at falling edges and never drives X or Z, so every sampled cycle is a clean access. The random phase biases addresses toward the two mailboxes and pulls busy low often. This makes sure that simultaneous set/clear and busy-cancelled cycles occur within the assumed input envelope.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // Number of ports sharing the mailbox pair
   localparam int NPORT = 2;

   // Per-port decoded effects of one sampled access
   typedef struct packed {
      logic set_peer;   // raise the other port's flag
      logic clr_own;    // acknowledge this port's flag
   } mbx_evt_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
   import mbx_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter logic [ADDR_W-1:0] SEND_ADDR = '1,
   parameter logic [ADDR_W-1:0] RECV_ADDR = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy_n,
   output mbx_evt_t          evt
);
   logic sel;
   logic hit_send;
   logic hit_recv;

   if (SEND_ADDR == RECV_ADDR) begin : g_chk_boxes
      $error("mbx_port_decode: send and receive mailboxes must differ");
   end

   always_comb begin
      sel          = !cs_n && busy_n;
      hit_send     = (addr == SEND_ADDR);
      hit_recv     = (addr == RECV_ADDR);
      evt.set_peer = sel && !we_n && hit_send;
      evt.clr_own  = sel && !oe_n && hit_recv;
   end

   // R6
   busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |-> (evt == '0));

   // R8
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (evt == '0));
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag #(
   parameter bit SET_WINS = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   logic flag_nx;

   if (SET_WINS) begin : g_set_first
      always_comb flag_nx = set || (flag && !clr);
   end else begin : g_clr_first
      always_comb flag_nx = !clr && (flag || set);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= flag_nx;
   end

   if (SET_WINS) begin : g_prio_chk
      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set |=> flag);
   end

   // R3
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);

   // R9
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter bit SET_WINS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_cs_n,
   input  logic              a_we_n,
   input  logic              a_oe_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_busy_n,
   input  logic              b_cs_n,
   input  logic              b_we_n,
   input  logic              b_oe_n,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_busy_n,
   output logic              a_irq_n,
   output logic              b_irq_n
);
   localparam logic [ADDR_W-1:0] BOX_TO_B = '1;
   localparam logic [ADDR_W-1:0] BOX_TO_A = BOX_TO_B - 1'b1;

   if (ADDR_W < 2) begin : g_chk_addr_w
      $error("mbx_irq_ctrl: ADDR_W must be at least 2");
   end

   logic              cs_n   [NPORT];
   logic              we_n   [NPORT];
   logic              oe_n   [NPORT];
   logic [ADDR_W-1:0] addr   [NPORT];
   logic              busy_n [NPORT];
   mbx_evt_t          evt    [NPORT];
   logic              flag   [NPORT];

   always_comb begin
      cs_n[0] = a_cs_n;   cs_n[1] = b_cs_n;
      we_n[0] = a_we_n;   we_n[1] = b_we_n;
      oe_n[0] = a_oe_n;   oe_n[1] = b_oe_n;
      addr[0] = a_addr;   addr[1] = b_addr;
      busy_n[0] = a_busy_n; busy_n[1] = b_busy_n;
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      localparam logic [ADDR_W-1:0] SEND = (p == 0) ? BOX_TO_B : BOX_TO_A;
      localparam logic [ADDR_W-1:0] RECV = (p == 0) ? BOX_TO_A : BOX_TO_B;

      mbx_port_decode #(
         .ADDR_W    (ADDR_W),
         .SEND_ADDR (SEND),
         .RECV_ADDR (RECV)
      ) dec_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .cs_n   (cs_n[p]),
         .we_n   (we_n[p]),
         .oe_n   (oe_n[p]),
         .addr   (addr[p]),
         .busy_n (busy_n[p]),
         .evt    (evt[p])
      );

      mbx_flag #(
         .SET_WINS (SET_WINS)
      ) flag_i (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (evt[NPORT-1-p].set_peer),
         .clr   (evt[p].clr_own),
         .flag  (flag[p])
      );
   end

   assign a_irq_n = !flag[0];
   assign b_irq_n = !flag[1];

   // R2
   send_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_cs_n && !a_we_n && a_busy_n && a_addr == BOX_TO_B) |=> !b_irq_n);

   // R4
   send_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!b_cs_n && !b_we_n && b_busy_n && b_addr == BOX_TO_A) |=> !a_irq_n);

   // R6
   both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_busy_n && !b_busy_n) |=> ($stable(a_irq_n) && $stable(b_irq_n)));
endmodule

// File: tb/mbx_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_cs_n, a_we_n, a_oe_n, a_busy_n;
   logic        b_cs_n, b_we_n, b_oe_n, b_busy_n;
   logic [10:0] a_addr, b_addr;
   logic        a_irq_n, b_irq_n;

   int errors = 0;
   int checks = 0;
   bit fa = 1'b0;   // model: port A flag
   bit fb = 1'b0;   // model: port B flag

   always #5 clk = ~clk;

   mbx_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_busy_n(a_busy_n),
      .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_busy_n(b_busy_n),
      .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
   );

   task automatic drv_a(input logic cs, we, oe, input logic [10:0] ad, input logic bz);
      a_cs_n = cs; a_we_n = we; a_oe_n = oe; a_addr = ad; a_busy_n = bz;
   endtask

   task automatic drv_b(input logic cs, we, oe, input logic [10:0] ad, input logic bz);
      b_cs_n = cs; b_we_n = we; b_oe_n = oe; b_addr = ad; b_busy_n = bz;
   endtask

   task automatic idle();
      drv_a(1, 1, 1, 11'h000, 1);
      drv_b(1, 1, 1, 11'h000, 1);
   endtask

   // advance one edge, update reference model from the sampled inputs, settle
   task automatic step();
      bit sa, ca, sb, cb;
      @(posedge clk);
      sb = !a_cs_n && !a_we_n && a_busy_n && a_addr == 11'h7FF;
      cb = !b_cs_n && !b_oe_n && b_busy_n && b_addr == 11'h7FF;
      sa = !b_cs_n && !b_we_n && b_busy_n && b_addr == 11'h7FE;
      ca = !a_cs_n && !a_oe_n && a_busy_n && a_addr == 11'h7FE;
      if (!rst_n) begin
         fa = 0; fb = 0;
      end else begin
         fa = sa ? 1'b1 : (ca ? 1'b0 : fa);
         fb = sb ? 1'b1 : (cb ? 1'b0 : fb);
      end
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic ea, input logic eb);
      checks++;
      if (a_irq_n !== ea || b_irq_n !== eb) begin
         errors++;
         $display("FAIL %s: a_irq_n=%b b_irq_n=%b expected a=%b b=%b",
                  tag, a_irq_n, b_irq_n, ea, eb);
      end
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle();
      step(); step();
      chk("R1", 1, 1);                        // reset state
      rst_n = 1'b1;
      step();
      chk("R1", 1, 1);

      drv_a(0, 0, 1, 11'h7FF, 1); step(); idle();
      chk("R2", 1, 0);                        // A sends to B
      step();
      chk("R8", 1, 0);                        // idle holds
      drv_a(0, 0, 1, 11'h7FE, 1); step(); idle();
      chk("R8", 1, 0);                        // A writes own receive box
      drv_b(0, 0, 1, 11'h7FF, 1); step(); idle();
      chk("R8", 1, 0);                        // B writes its receive box: not a read
      drv_b(0, 1, 0, 11'h7FF, 0); step(); idle();
      chk("R6", 1, 0);                        // busy cancels ack
      drv_b(0, 0, 0, 11'h7FF, 1); step(); idle();
      chk("R3", 1, 1);                        // ack with we_n low still clears
      drv_b(0, 0, 1, 11'h7FE, 1); step(); idle();
      chk("R4", 0, 1);                        // B sends to A
      drv_a(0, 1, 0, 11'h7FF, 1); step(); idle();
      chk("R8", 0, 1);                        // A reads its send box
      drv_a(1, 1, 0, 11'h7FE, 1); step(); idle();
      chk("R8", 0, 1);                        // deselected read
      drv_a(0, 1, 0, 11'h7FE, 1); step(); idle();
      chk("R5", 1, 1);                        // A acks
      drv_a(0, 0, 1, 11'h7FF, 0); step(); idle();
      chk("R6", 1, 1);                        // busy cancels send
      drv_a(0, 0, 1, 11'h7FF, 1); drv_b(0, 1, 0, 11'h7FF, 1); step(); idle();
      chk("R7", 1, 0);                        // set beats clear
      drv_b(0, 0, 0, 11'h7FE, 1); drv_a(0, 1, 0, 11'h7FE, 1); step(); idle();
      chk("R7", 0, 0);
      drv_a(0, 1, 0, 11'h7FE, 1); drv_b(0, 1, 0, 11'h7FF, 1); step(); idle();
      chk("R5", 1, 1);
      drv_a(0, 0, 1, 11'h7FF, 1);
      #2; chk("R9", 1, 1);                    // no change before the edge
      step(); idle();
      chk("R9", 1, 0);                        // one-cycle latency
      drv_b(0, 1, 0, 11'h7FF, 1); step(); idle();
      chk("R3", 1, 1);

      for (int i = 0; i < 3000; i++) begin
         logic [10:0] ad_a, ad_b;
         case ($urandom % 4)
            0: ad_a = 11'h7FF; 1: ad_a = 11'h7FE; default: ad_a = 11'($urandom);
         endcase
         case ($urandom % 4)
            0: ad_b = 11'h7FF; 1: ad_b = 11'h7FE; default: ad_b = 11'($urandom);
         endcase
         drv_a(($urandom % 4) == 0, 1'($urandom), 1'($urandom), ad_a, ($urandom % 4) != 0);
         drv_b(($urandom % 4) == 0, 1'($urandom), 1'($urandom), ad_b, ($urandom % 4) != 0);
         step();
         chk("R9", !fa, !fb);
      end

      idle();
      rst_n = 1'b0; #1;
      chk("R1", 1, 1);                        // asynchronous reset
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule